// File: doc/BRIEF.md
# Multi-Level Interrupt Dispatcher

This block sits beside a processor pipeline and decides, once per offered slot, whether a pending interrupt is accepted. Thirteen interrupt lines are sampled into an internal pending-set register. Each of six priority levels owns a fixed group of those lines, and a priority stage reports the highest level that has an enabled, pending line. When the pipeline raises its take strobe, the block compares that level with the current interrupt level derived from the processor status word (PS). If it accepts the interrupt, it produces the redirect address and the new PS value, and it records the interrupted PC and PS in its save registers.

Levels 2 to 6 are vectored directly. The block stores PC and PS in that level's save slots, writes the level into the PS level field, sets the exception-mode flag and jumps to the level's own vector. Level 1 is not vectored. It is turned into a general exception with cause code 4, and goes to the user or kernel exception vector according to the PS user-mode flag. If exception mode is already active, it goes to the double-exception vector instead, and the PC is saved in the double-exception PC register.

The control is a three-state machine. ST_IDLE moves to ST_TAKE when an interrupt is accepted. ST_TAKE always moves to ST_HOLD. ST_HOLD always returns to ST_IDLE. The accept pulse is high only in ST_TAKE. ST_HOLD gives the pipeline one cycle to load the new PS before another interrupt can be accepted.

Top module: `irqd_dispatch`

## Requirements
- R1: While reset is held, and after it is released with no interrupt taken: `new_ps` is 0x1F (0x10 when the interrupt option parameter is off), `taken` is 0, `pend_level` is 0, and every save register and `exc_cause` is 0.
- R2: Line-to-level map: line 0 is level 4; lines 1-3 are level 1; lines 4-5 are level 2; lines 6-7 are level 3; lines 8-9 are level 5; lines 10-12 are level 6. `pend_level` is the highest level that has a line both sampled high and enabled.
- R3: An interrupt is accepted only if all of these hold: `take_en` is high, the pending level is strictly above the current level, and the level's group has an enabled line in the pending set. The current level is PS[3:0], raised to the exception-mode level (1 by default) when PS bit 4 is set.
- R4: When level L (2 to 6) is accepted, the block writes PC to EPC slot L and PS to EPS slot L. It sets `new_ps` to the old PS with bits [3:0] replaced by L and bit 4 set. It sets `new_pc` to the level vector: 0x5FFF857C, 0x5FFF859C, 0x5FFF85BC, 0x5FFF85DC or 0x5FFF85FC for levels 2 to 6.
- R5: When level 1 is accepted with PS bit 4 clear, the block writes PC to EPC slot 1 and 4 to `exc_cause`, and sets `new_ps` to PS with bit 4 set. `new_pc` is the user vector 0x5FFF863C if PS bit 5 is set, and the kernel vector 0x5FFF861C otherwise.
- R6: When level 1 is accepted with PS bit 4 set, `new_pc` is the double vector 0x5FFF865C and `exc_cause` becomes 4. PC goes to `depc` when the double-PC register is configured, and EPC slot 1 is left unchanged; without that register, PC goes to EPC slot 1.
- R7: `taken` goes high in the cycle after the clock edge that sampled the accepting strobe, and stays high for exactly one cycle. Accepts are at least three cycles apart even if `take_en` stays high.
- R8: When no interrupt is accepted, `new_pc`, `new_ps` and all save registers keep their values.
- R9: `irq_lines` is registered before it is used. A line must already be high at the clock edge before the accepting edge, so a line that rises together with the strobe is not taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lines | input | 13 | Raw interrupt lines |
| int_enable | input | 13 | Per-line enable mask |
| ps_in | input | 8 | Current PS: [3:0] level, bit 4 exception mode, bit 5 user mode |
| pc_in | input | 32 | PC to save on accept |
| take_en | input | 1 | Pipeline offers an interrupt slot |
| taken | output | 1 | One-cycle accept pulse |
| new_pc | output | 32 | Redirect address |
| new_ps | output | 8 | PS value to load |
| pend_level | output | 3 | Highest pending enabled level |
| epc_flat | output | 192 | EPC slots 1..6, slot L at bits [(L-1)*32 +: 32] |
| eps_flat | output | 40 | EPS slots 2..6, slot L at bits [(L-2)*8 +: 8] |
| depc | output | 32 | Double-exception PC |
| exc_cause | output | 6 | Exception cause register |

## Verification
An error in the priority stage shows at the next accept. A wrong level leads to the wrong vector on `new_pc` and the wrong slot in `epc_flat` in the same cycle as `taken`. An error in the current-level compare shows as `taken` rising when it should stay low, or staying low when it should rise, one cycle after the strobe. An error in the state register shows as a pulse that lasts more than one cycle, or as an accept inside the hold gap. The bench therefore samples every output in the pulse cycle, and it also samples the quiet cycles that follow, where nothing may change.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam int PS_W     = 8;
    localparam int PS_LVL_W = 4;
    localparam int PS_EXCM  = 4;
    localparam int PS_UM    = 5;

    localparam int DEF_LINES  = 13;
    localparam int DEF_LEVELS = 6;

    // Line groups per level, index 0 unused (level 0 never interrupts)
    localparam logic [DEF_LEVELS:0][DEF_LINES-1:0] DEF_MASK = {
        13'h1C00,   // level 6
        13'h0300,   // level 5
        13'h0001,   // level 4: timer line only
        13'h00C0,   // level 3
        13'h0030,   // level 2
        13'h000E,   // level 1
        13'h0000    // level 0
    };

    localparam logic [DEF_LEVELS:0][31:0] DEF_VEC = {
        32'h5FFF85FC,
        32'h5FFF85DC,
        32'h5FFF85BC,
        32'h5FFF859C,
        32'h5FFF857C,
        32'h0000_0000,
        32'h0000_0000
    };

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TAKE = 2'd1,
        ST_HOLD = 2'd2
    } disp_state_e;

    // Effective current interrupt level from PS and the exception-mode level
    function automatic logic [PS_LVL_W-1:0] cur_level(
        input logic [PS_W-1:0] ps,
        input int              excm_lvl
    );
        logic [PS_LVL_W-1:0] lvl;
        lvl = ps[PS_LVL_W-1:0];
        if (ps[PS_EXCM] && (excm_lvl > int'(lvl)))
            lvl = PS_LVL_W'(excm_lvl);
        return lvl;
    endfunction

endpackage

// File: rtl/irqd_sampler.sv
module irqd_sampler
    import irqd_pkg::*;
#(
    parameter int NUM_LINES  = DEF_LINES,
    parameter int NUM_LEVELS = DEF_LEVELS,
    parameter int LVL_W      = $clog2(NUM_LEVELS + 1),
    parameter logic [NUM_LEVELS:0][NUM_LINES-1:0] LEVEL_MASK = DEF_MASK
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic [NUM_LINES-1:0] int_enable,
    output logic [NUM_LINES-1:0] intset_q,
    output logic [LVL_W-1:0]     pend_q
);

    logic [NUM_LEVELS:0] lvl_hit;
    logic [LVL_W-1:0]    pend_d;

    assign lvl_hit[0] = 1'b0;

    for (genvar l = 1; l <= NUM_LEVELS; l++) begin : g_hit
        assign lvl_hit[l] = |(LEVEL_MASK[l] & irq_lines & int_enable);
    end

    // Highest level wins
    always_comb begin
        pend_d = '0;
        for (int l = 1; l <= NUM_LEVELS; l++) begin
            if (lvl_hit[l])
                pend_d = LVL_W'(l);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            intset_q <= '0;
            pend_q   <= '0;
        end else begin
            intset_q <= irq_lines;
            pend_q   <= pend_d;
        end
    end

    AST_PEND_HAS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q != '0) |-> (intset_q != '0)); // R2

endmodule

// File: rtl/irqd_arbiter.sv
module irqd_arbiter
    import irqd_pkg::*;
#(
    parameter int NUM_LINES  = DEF_LINES,
    parameter int NUM_LEVELS = DEF_LEVELS,
    parameter int LVL_W      = $clog2(NUM_LEVELS + 1),
    parameter int PC_W       = 32,
    parameter logic [NUM_LEVELS:0][NUM_LINES-1:0] LEVEL_MASK = DEF_MASK,
    parameter logic [NUM_LEVELS:0][PC_W-1:0]      LEVEL_VEC  = DEF_VEC,
    parameter logic [PC_W-1:0] USER_VEC   = 32'h5FFF863C,
    parameter logic [PC_W-1:0] KERNEL_VEC = 32'h5FFF861C,
    parameter logic [PC_W-1:0] DOUBLE_VEC = 32'h5FFF865C,
    parameter int EXCM_LEVEL = 1,
    parameter bit HAS_DEPC   = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LINES-1:0]  intset,
    input  logic [NUM_LINES-1:0]  int_enable,
    input  logic [LVL_W-1:0]      pend,
    input  logic [PS_W-1:0]       ps_in,
    input  logic                  allow,
    output logic                  go,
    output logic [PC_W-1:0]       nxt_pc,
    output logic [PS_W-1:0]       nxt_ps,
    output logic [NUM_LEVELS-1:0] epc_we,
    output logic [NUM_LEVELS-2:0] eps_we,
    output logic                  depc_we,
    output logic                  cause_we
);

    logic [PS_LVL_W-1:0] cur_lvl;
    logic                mask_hit;

    always_comb begin
        cur_lvl  = cur_level(ps_in, EXCM_LEVEL);
        mask_hit = |(LEVEL_MASK[pend] & intset & int_enable);
        go       = allow
                   && (int'(pend) > int'(cur_lvl))
                   && (int'(pend) <= NUM_LEVELS)
                   && mask_hit;

        nxt_pc   = '0;
        nxt_ps   = ps_in;
        epc_we   = '0;
        eps_we   = '0;
        depc_we  = 1'b0;
        cause_we = 1'b0;

        if (go) begin
            if (int'(pend) > 1) begin
                nxt_pc                    = LEVEL_VEC[pend];
                nxt_ps[PS_LVL_W-1:0]      = PS_LVL_W'(pend);
                nxt_ps[PS_EXCM]           = 1'b1;
                for (int l = 2; l <= NUM_LEVELS; l++) begin
                    if (int'(pend) == l) begin
                        epc_we[l-1] = 1'b1;
                        eps_we[l-2] = 1'b1;
                    end
                end
            end else begin
                cause_we        = 1'b1;
                nxt_ps[PS_EXCM] = 1'b1;
                if (ps_in[PS_EXCM]) begin
                    nxt_pc = DOUBLE_VEC;
                    if (HAS_DEPC)
                        depc_we   = 1'b1;
                    else
                        epc_we[0] = 1'b1;
                end else begin
                    epc_we[0] = 1'b1;
                    nxt_pc    = ps_in[PS_UM] ? USER_VEC : KERNEL_VEC;
                end
            end
        end
    end

    AST_EPC_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(epc_we)); // R4

    AST_WE_NEEDS_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (epc_we != '0 || depc_we) |-> allow); // R3

endmodule

// File: rtl/irqd_savebank.sv
module irqd_savebank
    import irqd_pkg::*;
#(
    parameter int NUM_LEVELS = DEF_LEVELS,
    parameter int PC_W       = 32,
    parameter int CAUSE_W    = 6,
    parameter logic [CAUSE_W-1:0] CAUSE_L1 = 6'd4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [PC_W-1:0]            pc_in,
    input  logic [PS_W-1:0]            ps_in,
    input  logic [NUM_LEVELS-1:0]      epc_we,
    input  logic [NUM_LEVELS-2:0]      eps_we,
    input  logic                       depc_we,
    input  logic                       cause_we,
    output logic [NUM_LEVELS*PC_W-1:0] epc_flat,
    output logic [(NUM_LEVELS-1)*PS_W-1:0] eps_flat,
    output logic [PC_W-1:0]            depc,
    output logic [CAUSE_W-1:0]         exc_cause
);

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_epc
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                epc_flat[g*PC_W +: PC_W] <= '0;
            else if (epc_we[g])
                epc_flat[g*PC_W +: PC_W] <= pc_in;
        end
    end

    for (genvar g = 0; g < NUM_LEVELS - 1; g++) begin : g_eps
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                eps_flat[g*PS_W +: PS_W] <= '0;
            else if (eps_we[g])
                eps_flat[g*PS_W +: PS_W] <= ps_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depc      <= '0;
            exc_cause <= '0;
        end else begin
            if (depc_we)
                depc <= pc_in;
            if (cause_we)
                exc_cause <= CAUSE_L1;
        end
    end

    AST_EPC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (epc_we == '0) |=> $stable(epc_flat)); // R8

endmodule

// File: rtl/irqd_dispatch.sv
module irqd_dispatch
    import irqd_pkg::*;
#(
    parameter int NUM_LINES  = DEF_LINES,
    parameter int NUM_LEVELS = DEF_LEVELS,
    parameter int PC_W       = 32,
    parameter int CAUSE_W    = 6,
    parameter logic [NUM_LEVELS:0][NUM_LINES-1:0] LEVEL_MASK = DEF_MASK,
    parameter logic [NUM_LEVELS:0][PC_W-1:0]      LEVEL_VEC  = DEF_VEC,
    parameter logic [PC_W-1:0] USER_VEC   = 32'h5FFF863C,
    parameter logic [PC_W-1:0] KERNEL_VEC = 32'h5FFF861C,
    parameter logic [PC_W-1:0] DOUBLE_VEC = 32'h5FFF865C,
    parameter logic [CAUSE_W-1:0] CAUSE_L1 = 6'd4,
    parameter int EXCM_LEVEL = 1,
    parameter bit HAS_DEPC   = 1'b1,
    parameter bit INT_OPTION = 1'b1,
    localparam int LVL_W     = $clog2(NUM_LEVELS + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_LINES-1:0]           irq_lines,
    input  logic [NUM_LINES-1:0]           int_enable,
    input  logic [PS_W-1:0]                ps_in,
    input  logic [PC_W-1:0]                pc_in,
    input  logic                           take_en,
    output logic                           taken,
    output logic [PC_W-1:0]                new_pc,
    output logic [PS_W-1:0]                new_ps,
    output logic [LVL_W-1:0]               pend_level,
    output logic [NUM_LEVELS*PC_W-1:0]     epc_flat,
    output logic [(NUM_LEVELS-1)*PS_W-1:0] eps_flat,
    output logic [PC_W-1:0]                depc,
    output logic [CAUSE_W-1:0]             exc_cause
);

    localparam logic [PS_W-1:0] PS_RESET = INT_OPTION ? 8'h1F : 8'h10;

    disp_state_e           state_q, state_d;
    logic [NUM_LINES-1:0]  intset_q;
    logic                  allow, go;
    logic [PC_W-1:0]       nxt_pc;
    logic [PS_W-1:0]       nxt_ps;
    logic [NUM_LEVELS-1:0] epc_we;
    logic [NUM_LEVELS-2:0] eps_we;
    logic                  depc_we, cause_we;

    irqd_sampler #(
        .NUM_LINES  (NUM_LINES),
        .NUM_LEVELS (NUM_LEVELS),
        .LVL_W      (LVL_W),
        .LEVEL_MASK (LEVEL_MASK)
    ) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_lines  (irq_lines),
        .int_enable (int_enable),
        .intset_q   (intset_q),
        .pend_q     (pend_level)
    );

    assign allow = take_en && (state_q == ST_IDLE);

    irqd_arbiter #(
        .NUM_LINES  (NUM_LINES),
        .NUM_LEVELS (NUM_LEVELS),
        .LVL_W      (LVL_W),
        .PC_W       (PC_W),
        .LEVEL_MASK (LEVEL_MASK),
        .LEVEL_VEC  (LEVEL_VEC),
        .USER_VEC   (USER_VEC),
        .KERNEL_VEC (KERNEL_VEC),
        .DOUBLE_VEC (DOUBLE_VEC),
        .EXCM_LEVEL (EXCM_LEVEL),
        .HAS_DEPC   (HAS_DEPC)
    ) u_arbiter (
        .clk        (clk),
        .rst_n      (rst_n),
        .intset     (intset_q),
        .int_enable (int_enable),
        .pend       (pend_level),
        .ps_in      (ps_in),
        .allow      (allow),
        .go         (go),
        .nxt_pc     (nxt_pc),
        .nxt_ps     (nxt_ps),
        .epc_we     (epc_we),
        .eps_we     (eps_we),
        .depc_we    (depc_we),
        .cause_we   (cause_we)
    );

    irqd_savebank #(
        .NUM_LEVELS (NUM_LEVELS),
        .PC_W       (PC_W),
        .CAUSE_W    (CAUSE_W),
        .CAUSE_L1   (CAUSE_L1)
    ) u_savebank (
        .clk        (clk),
        .rst_n      (rst_n),
        .pc_in      (pc_in),
        .ps_in      (ps_in),
        .epc_we     (epc_we),
        .eps_we     (eps_we),
        .depc_we    (depc_we),
        .cause_we   (cause_we),
        .epc_flat   (epc_flat),
        .eps_flat   (eps_flat),
        .depc       (depc),
        .exc_cause  (exc_cause)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go) state_d = ST_TAKE;
            ST_TAKE: state_d = ST_HOLD;
            ST_HOLD: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            new_pc <= '0;
            new_ps <= PS_RESET;
        end else if (go) begin
            new_pc <= nxt_pc;
            new_ps <= nxt_ps;
        end
    end

    assign taken = (state_q == ST_TAKE);

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> !taken); // R7

    AST_PULSE_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(taken) |-> $past(take_en)); // R7

    AST_EXCM_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> new_ps[PS_EXCM]); // R4

    AST_HOLD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> !taken); // R7

endmodule

// File: tb/irqd_dispatch_test.sv
`timescale 1ns/1ps
module irqd_dispatch_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] irq_lines = '0;
    logic [12:0] int_enable = '1;
    logic [7:0]  ps_in = '0;
    logic [31:0] pc_in = '0;
    logic        take_en = 1'b0;

    logic        taken, taken_d;
    logic [31:0] new_pc, new_pc_d;
    logic [7:0]  new_ps, new_ps_d;
    logic [2:0]  pend_level, pend_level_d;
    logic [191:0] epc_flat, epc_flat_d;
    logic [39:0] eps_flat, eps_flat_d;
    logic [31:0] depc, depc_d;
    logic [5:0]  exc_cause, exc_cause_d;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irqd_dispatch uut (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .int_enable(int_enable),
        .ps_in(ps_in), .pc_in(pc_in), .take_en(take_en), .taken(taken),
        .new_pc(new_pc), .new_ps(new_ps), .pend_level(pend_level),
        .epc_flat(epc_flat), .eps_flat(eps_flat), .depc(depc), .exc_cause(exc_cause)
    );

    // Variant with exception-mode level 0 to reach the double path
    irqd_dispatch #(.EXCM_LEVEL(0)) uut_dbl (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .int_enable(int_enable),
        .ps_in(ps_in), .pc_in(pc_in), .take_en(take_en), .taken(taken_d),
        .new_pc(new_pc_d), .new_ps(new_ps_d), .pend_level(pend_level_d),
        .epc_flat(epc_flat_d), .eps_flat(eps_flat_d), .depc(depc_d), .exc_cause(exc_cause_d)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    typedef struct packed {
        logic [12:0] lines;
        logic [12:0] en;
        logic [7:0]  ps;
        logic [31:0] pc;
        logic        take;
        logic [2:0]  lvl;
        logic [31:0] xpc;
        logic [7:0]  xps;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t TBL [NV] = '{
        '{13'h0001, 13'h1FFF, 8'h00, 32'h0000_1000, 1'b1, 3'd4, 32'h5FFF85BC, 8'h14},
        '{13'h0001, 13'h1FFF, 8'h04, 32'h0000_1100, 1'b0, 3'd0, 32'h5FFF85BC, 8'h14},
        '{13'h1C01, 13'h1FFF, 8'h05, 32'h0000_2000, 1'b1, 3'd6, 32'h5FFF85FC, 8'h16},
        '{13'h0030, 13'h1FFF, 8'h21, 32'h0000_2400, 1'b1, 3'd2, 32'h5FFF857C, 8'h32},
        '{13'h0002, 13'h1FFF, 8'h20, 32'h0000_2800, 1'b1, 3'd1, 32'h5FFF863C, 8'h30},
        '{13'h0002, 13'h1FFF, 8'h00, 32'h0000_2C00, 1'b1, 3'd1, 32'h5FFF861C, 8'h10},
        '{13'h0002, 13'h1FFF, 8'h10, 32'h0000_3000, 1'b0, 3'd0, 32'h5FFF861C, 8'h10},
        '{13'h0002, 13'h0000, 8'h00, 32'h0000_3400, 1'b0, 3'd0, 32'h5FFF861C, 8'h10},
        '{13'h0340, 13'h00FF, 8'h00, 32'h0000_3800, 1'b1, 3'd3, 32'h5FFF859C, 8'h13}
    };

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [191:0] epc_snap;
        logic [31:0]  pc_snap;
        logic [7:0]   ps_snap;

        irq_lines = 13'h0001;
        repeat (3) @(negedge clk);
        // R1: values during reset
        chk("R1 taken in reset", taken, 0);
        chk("R1 new_ps in reset", new_ps, 8'h1F);
        chk("R1 pend_level in reset", pend_level, 0);
        irq_lines = '0;
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 epc after reset", epc_flat, 0);
        chk("R1 eps after reset", eps_flat, 0);
        chk("R1 cause after reset", exc_cause, 0);
        chk("R1 depc after reset", depc, 0);
        chk("R1 new_ps after reset", new_ps, 8'h1F);

        // R6: level 1 with exception mode set on the variant
        irq_lines = 13'h0002;
        @(negedge clk);
        ps_in = 8'h10; pc_in = 32'h0000_0ABC; take_en = 1'b1;
        @(negedge clk);
        take_en = 1'b0;
        chk("R6 double taken", taken_d, 1);
        chk("R6 double vector", new_pc_d, 32'h5FFF865C);
        chk("R6 double ps", new_ps_d, 8'h10);
        chk("R6 depc", depc_d, 32'h0000_0ABC);
        chk("R6 epc1 untouched", epc_flat_d[31:0], 0);
        chk("R6 cause", exc_cause_d, 6'd4);
        chk("R3 excm level blocks level 1", taken, 0);
        repeat (2) @(negedge clk);
        irq_lines = '0;
        @(negedge clk);

        // Table walk: R2, R3, R4, R5, R8
        for (int i = 0; i < NV; i++) begin
            irq_lines  = TBL[i].lines;
            int_enable = TBL[i].en;
            @(negedge clk);
            chk("R2 pend_level", pend_level, (TBL[i].take) ? TBL[i].lvl : pend_level);
            ps_in = TBL[i].ps; pc_in = TBL[i].pc; take_en = 1'b1;
            @(negedge clk);
            take_en = 1'b0;
            chk("R3 taken", taken, TBL[i].take);
            chk("R4 new_pc", new_pc, TBL[i].xpc);
            chk("R4 new_ps", new_ps, TBL[i].xps);
            if (TBL[i].take) begin
                chk("R4 epc slot", epc_flat[(int'(TBL[i].lvl)-1)*32 +: 32], TBL[i].pc);
                if (TBL[i].lvl > 1)
                    chk("R4 eps slot", eps_flat[(int'(TBL[i].lvl)-2)*8 +: 8], TBL[i].ps);
                else
                    chk("R5 cause", exc_cause, 6'd4);
            end
            repeat (2) @(negedge clk);
            irq_lines = '0;
            int_enable = '1;
            @(negedge clk);
        end

        // R8: no strobe, pending line, nothing changes
        epc_snap = epc_flat; pc_snap = new_pc; ps_snap = new_ps;
        irq_lines = 13'h0001; ps_in = 8'h00; pc_in = 32'h0000_7777;
        repeat (5) @(negedge clk);
        chk("R8 no taken without strobe", taken, 0);
        chk("R8 epc held", epc_flat, epc_snap);
        chk("R8 new_pc held", new_pc, pc_snap);
        chk("R8 new_ps held", new_ps, ps_snap);

        // R7: strobe held high, pattern 1,0,0,1
        take_en = 1'b1;
        @(negedge clk); chk("R7 pulse 1", taken, 1);
        @(negedge clk); chk("R7 gap a", taken, 0);
        @(negedge clk); chk("R7 gap b", taken, 0);
        @(negedge clk); chk("R7 pulse 2", taken, 1);
        take_en = 1'b0;
        irq_lines = '0;
        repeat (3) @(negedge clk);

        // R9: line rising with the strobe is not yet visible
        irq_lines = 13'h0001; take_en = 1'b1; pc_in = 32'h0000_9000;
        @(negedge clk);
        chk("R9 not taken same edge", taken, 0);
        @(negedge clk);
        take_en = 1'b0;
        chk("R9 taken next edge", taken, 1);
        chk("R9 epc4", epc_flat[3*32 +: 32], 32'h0000_9000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule